// File: doc/BRIEF.md
# ALU with Conditional Status Flags

This block is the arithmetic stage of a small 16-bit datapath. It adds, subtracts, ANDs or ORs two operands and produces the result combinationally in the same cycle. The second operand is either a full register value or a 3-bit constant, zero-extended, taken from the instruction's register field.

Alongside the result it computes four status flags: negative, zero, carry and overflow. The flags are captured into a register on a rising clock edge, but only when an execute strobe is high and the instruction asks for a flag update. When either is low, the stored flags stay as they were. The register can then drive conditional branch decisions made later in the pipeline.

Top module: `alu_flags_unit`

## Requirements
- R1: With op_i = 2'b00 the result is operand A plus operand B, modulo 2^16.
- R2: With op_i = 2'b01 the result is operand A minus operand B, modulo 2^16.
- R3: With op_i = 2'b10 the result is the bitwise AND of the operands.
- R4: With op_i = 2'b11 the result is the bitwise OR of the operands.
- R5: When imm_sel_i is 1, operand B is imm_i zero-extended to 16 bits and b_i has no effect on the result. When imm_sel_i is 0, operand B is b_i.
- R6: flags_o[3] (negative) captures bit 15 of the result. flags_o[2] (zero) captures whether the result equals zero.
- R7: flags_o[1] (carry) captures the carry out of an add, or the no-borrow condition (A >= B unsigned) of a subtract. flags_o[0] (overflow) captures signed overflow of an add or subtract. AND and OR capture 0 in both bits.
- R8: flags_o loads the new flags at a rising clk_i edge only when valid_i and upd_i are both 1. Otherwise it holds its value.
- R9: While rst_ni is low, flags_o is 4'b0000, independent of the clock.
- R10: result_o depends only on the current inputs, with no clock latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| a_i | input | 16 | Operand A |
| b_i | input | 16 | Register operand B |
| op_i | input | 2 | Operation: 00 add, 01 sub, 10 and, 11 or |
| imm_sel_i | input | 1 | 1 selects the constant as operand B |
| imm_i | input | 3 | Unsigned constant operand |
| upd_i | input | 1 | Instruction requests a flag update |
| valid_i | input | 1 | Execute strobe |
| result_o | output | 16 | Combinational result |
| flags_o | output | 4 | Registered flags {N, Z, C, V} |

## Verification
A faulty flag register does not show up on result_o. It shows up on flags_o at the first edge after a qualifying update, or after an edge that should have held the flags. The bench therefore compares flags_o both just before and just after every edge.

Errors in carry and overflow generation are confined to edge cases: unsigned wrap, signed wrap and equal operands in a subtract. These cases are driven explicitly rather than left to chance.

A wrong operand select shows immediately on result_o. To expose it, the constant path is exercised with nonzero junk on b_i.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned IMM_W  = 3;

  typedef enum logic [1:0] {
    OP_ADD = 2'b00,
    OP_SUB = 2'b01,
    OP_AND = 2'b10,
    OP_OR  = 2'b11
  } alu_op_e;

  typedef struct packed {
    logic neg;
    logic zero;
    logic carry;
    logic ovf;
  } alu_flags_t;
endpackage

// File: rtl/alu_opsel.sv
module alu_opsel #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned IMM_W  = 3
) (
  input  logic [DATA_W-1:0] b_i,
  input  logic              imm_sel_i,
  input  logic [IMM_W-1:0]  imm_i,
  output logic [DATA_W-1:0] opb_o
);
  localparam int unsigned PAD_W = DATA_W - IMM_W;

  always_comb begin
    if (imm_sel_i) opb_o = {{PAD_W{1'b0}}, imm_i};
    else           opb_o = b_i;
  end
endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  alu_op_e           op_i,
  output logic [DATA_W-1:0] res_o,
  output alu_flags_t        flags_o
);
  localparam int unsigned MSB = DATA_W - 1;

  logic [DATA_W:0] ext;
  logic            arith;
  logic            b_msb_eff;

  always_comb begin
    arith     = 1'b1;
    b_msb_eff = b_i[MSB];
    ext       = '0;
    res_o     = '0;
    unique case (op_i)
      OP_ADD: begin
        ext   = {1'b0, a_i} + {1'b0, b_i};
        res_o = ext[DATA_W-1:0];
      end
      OP_SUB: begin
        // two's complement add; carry out is the no-borrow bit
        ext       = {1'b0, a_i} + {1'b0, ~b_i} + {{DATA_W{1'b0}}, 1'b1};
        res_o     = ext[DATA_W-1:0];
        b_msb_eff = ~b_i[MSB];
      end
      OP_AND: begin
        arith = 1'b0;
        res_o = a_i & b_i;
      end
      OP_OR: begin
        arith = 1'b0;
        res_o = a_i | b_i;
      end
      default: ;
    endcase
  end

  always_comb begin
    flags_o.neg   = res_o[MSB];
    flags_o.zero  = (res_o == '0);
    flags_o.carry = arith & ext[DATA_W];
    flags_o.ovf   = arith & (a_i[MSB] == b_msb_eff) & (res_o[MSB] != a_i[MSB]);
  end
endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg
  import alu_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  alu_flags_t flags_d_i,
  output alu_flags_t flags_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flags_q_o <= '0;
    else if (load_i) flags_q_o <= flags_d_i;
  end
endmodule

// File: rtl/alu_flags_unit.sv
module alu_flags_unit
  import alu_pkg::*;
#(
  parameter int unsigned WIDTH = alu_pkg::DATA_W,
  parameter int unsigned CST_W = alu_pkg::IMM_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [1:0]       op_i,
  input  logic             imm_sel_i,
  input  logic [CST_W-1:0] imm_i,
  input  logic             upd_i,
  input  logic             valid_i,
  output logic [WIDTH-1:0] result_o,
  output logic [3:0]       flags_o
);
  logic [WIDTH-1:0] opb;
  alu_flags_t       flags_d;
  alu_flags_t       flags_q;

  alu_opsel #(.DATA_W(WIDTH), .IMM_W(CST_W)) u_opsel (
    .b_i       (b_i),
    .imm_sel_i (imm_sel_i),
    .imm_i     (imm_i),
    .opb_o     (opb)
  );

  alu_core #(.DATA_W(WIDTH)) u_core (
    .a_i     (a_i),
    .b_i     (opb),
    .op_i    (alu_op_e'(op_i)),
    .res_o   (result_o),
    .flags_o (flags_d)
  );

  alu_flag_reg u_flags (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (valid_i & upd_i),
    .flags_d_i (flags_d),
    .flags_q_o (flags_q)
  );

  assign flags_o = flags_q;
endmodule

// File: rtl/alu_flags_unit_chk.sv
module alu_flags_unit_chk #(
  parameter int unsigned WIDTH = 16,
  parameter int unsigned CST_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic [1:0]       op_i,
  input logic             imm_sel_i,
  input logic [CST_W-1:0] imm_i,
  input logic             upd_i,
  input logic             valid_i,
  input logic [WIDTH-1:0] result_o,
  input logic [3:0]       flags_o
);
  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_i && upd_i) |=> $stable(flags_o));

  assert_zero_neg_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && upd_i) |=> (flags_o[2] == ($past(result_o) == '0)) &&
                           (flags_o[3] == $past(result_o[WIDTH-1])));

  assert_logic_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && upd_i && op_i[1]) |=> flags_o[1:0] == 2'b00);

  assert_and_result_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 2'b10 && !imm_sel_i) |-> result_o == (a_i & b_i));

  assert_imm_width_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (imm_sel_i && op_i == 2'b10) |-> result_o[WIDTH-1:CST_W] == '0);

  assert_reset_R9: assert property (@(posedge clk_i)
    !rst_ni |-> flags_o == 4'b0000);
endmodule

bind alu_flags_unit alu_flags_unit_chk #(.WIDTH(WIDTH), .CST_W(CST_W)) u_chk (.*);

// File: tb/alu_flags_unit_test.sv
module alu_flags_unit_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] a_i = '0, b_i = '0;
  logic [1:0]  op_i = '0;
  logic        imm_sel_i = 1'b0;
  logic [2:0]  imm_i = '0;
  logic        upd_i = 1'b0, valid_i = 1'b0;
  logic [15:0] result_o;
  logic [3:0]  flags_o;

  int n_cmp = 0;
  int n_bad = 0;
  logic [3:0] exp_flags = 4'b0000;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  alu_flags_unit uut (.*);

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [15:0] a, input logic [15:0] b, input logic [1:0] op,
                      input logic isel, input logic [2:0] imm, input logic upd, input logic vld);
    int ua, ub, ur, sa, sb, sr;
    logic [3:0] nf;
    string rtag;
    @(negedge clk_i);
    a_i = a; b_i = b; op_i = op; imm_sel_i = isel; imm_i = imm; upd_i = upd; valid_i = vld;
    ua = int'(a);
    ub = isel ? int'(imm) : int'(b);
    sa = int'($signed(a));
    sb = isel ? int'(imm) : int'($signed(b));
    nf = 4'b0000;
    case (op)
      2'd0: begin
        ur = ua + ub; sr = sa + sb;
        nf[1] = (ur > 65535);
        nf[0] = (sr > 32767 || sr < -32768);
        rtag = "R1";
      end
      2'd1: begin
        ur = ua - ub; sr = sa - sb;
        nf[1] = (ua >= ub);
        nf[0] = (sr > 32767 || sr < -32768);
        rtag = "R2";
      end
      2'd2: begin ur = ua & ub; rtag = "R3"; end
      default: begin ur = ua | ub; rtag = "R4"; end
    endcase
    ur = ur & 32'hFFFF;
    nf[3] = ur[15];
    nf[2] = (ur == 0);
    #1;
    // R10: result visible in the same cycle
    check(isel ? "R5" : rtag, result_o, 16'(ur));
    check("R8", {12'h0, flags_o}, {12'h0, exp_flags});
    if (vld && upd) exp_flags = nf;
    @(posedge clk_i); #1;
    check("R6", {14'h0, flags_o[3:2]}, {14'h0, exp_flags[3:2]});
    check("R7", {14'h0, flags_o[1:0]}, {14'h0, exp_flags[1:0]});
  endtask

  initial begin
    #100000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    #5;
    check("R9", {12'h0, flags_o}, 16'h0);
    @(negedge clk_i); rst_ni = 1'b1;
    step(16'h0001, 16'h0002, 2'd0, 0, 3'd0, 1, 1);
    step(16'hFFFF, 16'h0001, 2'd0, 0, 3'd0, 1, 1); // carry, zero
    step(16'h7FFF, 16'h0001, 2'd0, 0, 3'd0, 1, 1); // signed overflow
    step(16'h0010, 16'hABCD, 2'd1, 1, 3'd3, 1, 1); // sub #3, b ignored
    step(16'h0003, 16'h0005, 2'd1, 0, 3'd0, 1, 1); // borrow
    step(16'h0005, 16'h0005, 2'd1, 0, 3'd0, 1, 1); // equal: zero, no borrow
    step(16'h8000, 16'h0001, 2'd1, 0, 3'd0, 1, 1); // signed overflow
    step(16'hF0F0, 16'h0FF0, 2'd2, 0, 3'd0, 1, 1);
    step(16'hF0F0, 16'h0F0F, 2'd3, 0, 3'd0, 1, 1);
    step(16'hFFFF, 16'h1234, 2'd2, 1, 3'd7, 1, 1); // and with #7
    step(16'h0000, 16'h0000, 2'd0, 0, 3'd0, 0, 1); // no update
    step(16'h0000, 16'h0000, 2'd0, 0, 3'd0, 1, 0); // not valid
    step(16'h0000, 16'h0000, 2'd3, 0, 3'd0, 1, 1);
    lfsr = 16'hACE1;
    for (int i = 0; i < 300; i++) begin
      logic [15:0] x, y;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      x = lfsr;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      y = lfsr;
      step(x, y, y[1:0], x[0], y[4:2], x[3] | x[4], x[5] | x[6]);
    end
    @(negedge clk_i); rst_ni = 1'b0; #1;
    check("R9", {12'h0, flags_o}, 16'h0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule